// File: doc/BRIEF.md
# Dual-Slot Edge Capture Unit

This block watches an asynchronous external pin and records when chosen transitions on it happen. It samples the pin through a synchronizer, looks for rising, falling or either edges according to a two-bit mode, and stores the free-running count it receives from the timer core. Each store goes into the next of two capture slots. A single-cycle event output goes high after either the first or the second store, as software selects.

When both slots hold values, the block ignores every further edge. Software re-opens the slots with a restart strobe, which it issues when it acknowledges the capture interrupt in the timer core. Moving the mode from disabled to any active setting also re-opens the slots. A soft reset clears both slots and the slot pointer. The interrupt status bit itself is stored in the timer core, outside this block.

Top module: `edge_capture_unit`

## Requirements
- R1: `cap_mode` selects which synchronized pin transitions qualify. 0 means no transition qualifies. 1 means low-to-high only. 2 means high-to-low only. 3 means both directions.
- R2: When `pin_is_input` is 0, no transition qualifies. The slots keep their values and `cap_evt` stays low.
- R3: The first qualifying transition after the slots open stores the count into `cap_a` and the second stores it into `cap_b`. Once both slots are filled, further transitions change neither slot and raise no event.
- R4: When `second_sel` is 0, `cap_evt` goes high after the store into `cap_a`. When it is 1, `cap_evt` goes high after the store into `cap_b`. No other store raises the event.
- R5: A cycle with `restart` high returns the slot pointer to the first slot. A transition detected in that same cycle is not stored.
- R6: A cycle in which `cap_mode` is nonzero, and in which it was 0 on the previous clock edge, returns the slot pointer to the first slot. A transition detected in that cycle is not stored.
- R7: `soft_rst` high clears `cap_a`, `cap_b` and the slot pointer, and suppresses any store and any event in that cycle. It has priority over `restart` and over an edge.
- R8: The pin passes through two flops before edge detection. If `pin_in` changes before rising edge k, the store happens at rising edge k+2 and takes the `count_in` value present at that edge. `cap_evt` is high in the cycle that follows that edge.
- R9: While `rst_n` is low, and directly after it goes high, `cap_a` and `cap_b` are 0 and `cap_evt` is 0.
- R10: `cap_evt` is high for exactly one cycle per qualifying store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of both slots and the slot pointer |
| pin_in | input | 1 | Asynchronous external pin |
| count_in | input | COUNT_W | Live timer count |
| cap_mode | input | 2 | Edge selection: 0 off, 1 rising, 2 falling, 3 both |
| pin_is_input | input | 1 | 1 when the pin is configured as an input |
| second_sel | input | 1 | 0: event after first store, 1: event after second store |
| restart | input | 1 | Strobe that re-opens the slots |
| cap_a | output | COUNT_W | First capture slot |
| cap_b | output | COUNT_W | Second capture slot |
| cap_evt | output | 1 | Single-cycle capture event |

## Verification
A wrong slot pointer shows at the ports within one qualifying edge. A pointer stuck on the first slot overwrites `cap_a` where `cap_b` should change. A pointer that never saturates lets a third edge overwrite a filled slot. A pointer that is not cleared by restart or by arming leaves both slots frozen. An extra or missing synchronizer stage moves the store by one cycle, so `count_in`, which changes every cycle, makes the captured value differ from the expected one on the first edge. A wrong event selection shows as `cap_evt` arriving one store early or late, or never.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_BOTH = 2'd3
  } cap_mode_e;

  localparam int CAP_SLOTS = 2;
  localparam int CAP_IDX_W = $clog2(CAP_SLOTS + 1);

  // Edge qualification for one sample pair of the synchronized pin.
  function automatic logic edge_qualifies(cap_mode_e m, logic prev, logic cur);
    case (m)
      CAP_RISE: return (!prev) && cur;
      CAP_FALL: return prev && (!cur);
      CAP_BOTH: return prev ^ cur;
      default:  return 1'b0;
    endcase
  endfunction

  // Re-arming happens when the mode leaves the disabled setting.
  function automatic logic mode_arms(cap_mode_e old_m, cap_mode_e new_m);
    return (old_m == CAP_OFF) && (new_m != CAP_OFF);
  endfunction

  // Slot index after which the event is raised.
  function automatic logic [CAP_IDX_W-1:0] event_slot(logic sel);
    return sel ? CAP_IDX_W'(1) : CAP_IDX_W'(0);
  endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge
  import cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level,
  input  cap_mode_e mode,
  input  logic      enable,
  output logic      hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign hit = enable && edge_qualifies(mode, prev_q, level);

  // R1: a rising-only hit needs a low sample on the previous cycle
  p_rise_prev_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == CAP_RISE) |-> (level && !$past(level)));

  // R1: a falling-only hit needs a high sample on the previous cycle
  p_fall_prev_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == CAP_FALL) |-> (!level && $past(level)));
endmodule

// File: rtl/cap_slots.sv
module cap_slots
  import cap_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               hit,
  input  logic               reopen,
  input  logic               second_sel,
  input  logic [COUNT_W-1:0] count_in,
  output logic [COUNT_W-1:0] slot_a,
  output logic [COUNT_W-1:0] slot_b,
  output logic               evt
);
  logic [CAP_IDX_W-1:0] idx_q;
  logic [COUNT_W-1:0]   slot_q [CAP_SLOTS];
  logic                 room;
  logic                 store;
  logic                 evt_d;

  assign room  = (idx_q < CAP_IDX_W'(CAP_SLOTS));
  assign store = hit && room && !reopen && !soft_rst;
  assign evt_d = store && (idx_q == event_slot(second_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      evt   <= 1'b0;
    end else begin
      evt <= evt_d;
      if (soft_rst || reopen) idx_q <= '0;
      else if (store)         idx_q <= idx_q + 1'b1;
    end
  end

  generate
    for (genvar s = 0; s < CAP_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    slot_q[s] <= '0;
        else if (soft_rst)                             slot_q[s] <= '0;
        else if (store && idx_q == CAP_IDX_W'(s))      slot_q[s] <= count_in;
      end
    end
  endgenerate

  assign slot_a = slot_q[0];
  assign slot_b = slot_q[1];

  // R3: the pointer never passes the last slot
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= CAP_IDX_W'(CAP_SLOTS));

  // R3: full slots stay frozen until reopened or cleared
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == CAP_IDX_W'(CAP_SLOTS) && !reopen && !soft_rst)
      |=> ($stable(slot_q[0]) && $stable(slot_q[1]) && !evt));

  // R4: the event follows the store into the selected slot
  p_evt_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (idx_q == ($past(second_sel) ? CAP_IDX_W'(2) : CAP_IDX_W'(1))));

  // R5 and R6: reopening returns the pointer to the first slot
  p_reopen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reopen |=> (idx_q == '0 && !evt));

  // R7: soft reset clears the slots and the pointer
  p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (idx_q == '0 && slot_q[0] == '0 && slot_q[1] == '0 && !evt));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int COUNT_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               pin_in,
  input  logic [COUNT_W-1:0] count_in,
  input  logic [1:0]         cap_mode,
  input  logic               pin_is_input,
  input  logic               second_sel,
  input  logic               restart,
  output logic [COUNT_W-1:0] cap_a,
  output logic [COUNT_W-1:0] cap_b,
  output logic               cap_evt
);
  cap_mode_e mode;
  cap_mode_e mode_prev_q;
  logic      pin_sync;
  logic      edge_hit;
  logic      arm;
  logic      reopen;

  assign mode   = cap_mode_e'(cap_mode);
  assign arm    = mode_arms(mode_prev_q, mode);
  assign reopen = restart || arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_prev_q <= CAP_OFF;
    else        mode_prev_q <= mode;
  end

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  cap_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (pin_sync),
    .mode   (mode),
    .enable (pin_is_input),
    .hit    (edge_hit)
  );

  cap_slots #(.COUNT_W(COUNT_W)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .hit        (edge_hit),
    .reopen     (reopen),
    .second_sel (second_sel),
    .count_in   (count_in),
    .slot_a     (cap_a),
    .slot_b     (cap_b),
    .evt        (cap_evt)
  );

  // R2: an output-configured pin leaves the slots and the event untouched
  p_output_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_is_input && !soft_rst) |=> ($stable(cap_a) && $stable(cap_b) && !cap_evt));

  // R6: arming blocks a store in the same cycle
  p_arm_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !soft_rst) |=> ($stable(cap_a) && $stable(cap_b) && !cap_evt));
endmodule

// File: tb/sim_edge_capture_unit.sv
module sim_edge_capture_unit;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          soft_rst;
  logic          pin_in;
  logic [CW-1:0] count_in;
  logic [1:0]    cap_mode;
  logic          pin_is_input;
  logic          second_sel;
  logic          restart;
  logic [CW-1:0] cap_a;
  logic [CW-1:0] cap_b;
  logic          cap_evt;

  always #5 clk = ~clk;

  edge_capture_unit #(.COUNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pin_in(pin_in),
    .count_in(count_in), .cap_mode(cap_mode), .pin_is_input(pin_is_input),
    .second_sel(second_sel), .restart(restart),
    .cap_a(cap_a), .cap_b(cap_b), .cap_evt(cap_evt)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string phase = "R9";

  // Reference state
  logic          m_s1, m_s2, m_p;
  logic [1:0]    m_mprev;
  logic [CW-1:0] m_a, m_b;
  int            m_idx;
  logic          m_evt;

  function automatic logic want_hit(logic [1:0] md, logic p, logic c);
    return (md[0] && !p && c) || (md[1] && p && !c);
  endfunction

  task automatic model_clock();
    logic h, ev;
    h  = pin_is_input && want_hit(cap_mode, m_p, m_s2);
    ev = 1'b0;
    if (soft_rst) begin
      m_a = '0; m_b = '0; m_idx = 0;
    end else if (restart || (m_mprev == 2'd0 && cap_mode != 2'd0)) begin
      m_idx = 0;
    end else if (h && m_idx < 2) begin
      if (m_idx == 0) m_a = count_in; else m_b = count_in;
      ev = (m_idx == (second_sel ? 1 : 0));
      m_idx++;
    end
    m_p = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    m_mprev = cap_mode;
    m_evt = ev;
  endtask

  task automatic compare();
    vectors++;
    if (cap_a !== m_a || cap_b !== m_b || cap_evt !== m_evt) begin
      miscompares++;
      $display("FAIL %s: got a=%h b=%h evt=%b, expected a=%h b=%h evt=%b",
               phase, cap_a, cap_b, cap_evt, m_a, m_b, m_evt);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    model_clock();
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      count_in = count_in + 32'h0000_0101;
      tick();
    end
  endtask

  task automatic pulse_restart();
    restart = 1'b1; tick(); restart = 1'b0;
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: got no finish, expected end of run");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; soft_rst = 1'b0; pin_in = 1'b0; count_in = 32'h1000_0000;
    cap_mode = 2'd0; pin_is_input = 1'b0; second_sel = 1'b0; restart = 1'b0;
    m_s1 = 0; m_s2 = 0; m_p = 0; m_mprev = 0; m_a = '0; m_b = '0; m_idx = 0; m_evt = 0;
    repeat (3) @(negedge clk);
    phase = "R9"; compare();          // reset state
    rst_n = 1'b1;
    run(2);

    // R1: rising only
    phase = "R1"; pin_is_input = 1'b1; cap_mode = 2'd1;
    run(2);
    pin_in = 1'b1; run(4); pin_in = 1'b0; run(4);
    pulse_restart();
    cap_mode = 2'd2;                  // falling only, no arming (active to active)
    pin_in = 1'b1; run(4); pin_in = 1'b0; run(4);
    pulse_restart();
    cap_mode = 2'd3;
    pin_in = 1'b1; run(4); pin_in = 1'b0; run(4);

    // R2: pin configured as output
    phase = "R2"; pulse_restart(); pin_is_input = 1'b0;
    for (int i = 0; i < 4; i++) begin pin_in = ~pin_in; run(3); end
    pin_is_input = 1'b1;

    // R3: fill both slots then overflow attempts
    phase = "R3"; pulse_restart();
    for (int i = 0; i < 6; i++) begin pin_in = ~pin_in; run(4); end

    // R4: event after second store
    phase = "R4"; second_sel = 1'b1; pulse_restart();
    for (int i = 0; i < 3; i++) begin pin_in = ~pin_in; run(4); end
    second_sel = 1'b0;

    // R10: single-cycle pulse after a first store
    phase = "R10"; pulse_restart();
    pin_in = ~pin_in; run(5);

    // R5: restart in the detection cycle
    phase = "R5"; pulse_restart();
    pin_in = ~pin_in; run(2); pulse_restart(); run(3);
    pin_in = ~pin_in; run(4);

    // R6: fill, disable, re-enable
    phase = "R6";
    for (int i = 0; i < 3; i++) begin pin_in = ~pin_in; run(4); end
    cap_mode = 2'd0; run(2);
    pin_in = ~pin_in; run(1); cap_mode = 2'd3; run(1); run(4);
    pin_in = ~pin_in; run(4);

    // R7: soft reset, also against restart and an edge
    phase = "R7"; soft_rst = 1'b1; tick(); soft_rst = 1'b0; run(2);
    pin_in = ~pin_in; run(2); soft_rst = 1'b1; restart = 1'b1; tick();
    soft_rst = 1'b0; restart = 1'b0; run(3);

    // R8: random traffic with a changing count each cycle
    phase = "R8";
    for (int i = 0; i < 4000; i++) begin
      count_in = $urandom;
      if ($urandom_range(0, 2) == 0) pin_in = ~pin_in;
      if ($urandom_range(0, 40) == 0) cap_mode = 2'($urandom_range(0, 3));
      pin_is_input = ($urandom_range(0, 9) != 0);
      second_sel = ($urandom_range(0, 30) == 0) ? ~second_sel : second_sel;
      restart = ($urandom_range(0, 12) == 0);
      soft_rst = ($urandom_range(0, 150) == 0);
      tick();
    end
    restart = 1'b0; soft_rst = 1'b0;
    run(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule